// File: doc/BRIEF.md
# Two-lane SIMD multiply-accumulate unit

This unit splits each 64-bit operand into two 32-bit lanes that are processed side by side by identical hardware. In each lane the signed low halfwords of the two operands are multiplied. The 32-bit product can be returned directly, or it can be added into that lane's half of a dedicated 64-bit accumulator. Further operations clear the accumulator or load it from an operand. An operation is issued by asserting a valid strobe with an operation code and two operands. Its result appears at the output a fixed four cycles later.

The pipeline has four stages: operand capture, multiply, accumulate and output. The accumulator register sits inside the accumulate stage and is updated there. An accumulating operation issued in the next cycle therefore reads the new value without waiting, and a chain of dependent operations runs at one per cycle. Signed overflow in the accumulate adder is flagged next to the result. It is also latched per lane into a small status register that software can write. When the interrupt enable bit of that register is set and any latched flag is set, an interrupt request is raised.

Top module: `simd_mac`

## Requirements
- R1: An operation sampled with `in_valid` high at rising edge n drives `out_valid` high, with its result, after rising edge n+3. Operations issued in consecutive cycles come out in consecutive cycles, with no stall.
- R2: Op code 2'b00 (multiply). For each lane i, with bits [32i+31:32i], the lane result is the signed product of halfword bits [32i+15:32i] of `in_a` and `in_b`, as 32 bits. Upper halfword bits are ignored. The product is also written into that lane's accumulator half.
- R3: Op code 2'b01 (multiply-accumulate). Each lane adds its product to its accumulator half, modulo 2^32. The sum becomes both the new accumulator half and the lane result. An issue in the very next cycle already sees the updated value.
- R4: Op code 2'b10 (clear). Both accumulator halves and the result become zero.
- R5: Op code 2'b11 (load). The accumulator takes the full value of `in_a`, and the result equals `in_a`.
- R6: `out_ovf[i]` is high with a result exactly when lane i of a multiply-accumulate produced signed 32-bit overflow. Lanes are independent of each other, and other op codes never flag overflow.
- R7: `status[1:0]` are sticky per-lane overflow flags and `status[2]` is the interrupt enable. Writing `sr_wr` loads `status` from `sr_wdata`. An overflow latched at the same edge as a write still sets its flag.
- R8: `irq` is registered. It is high one cycle after `status[2]` is set while any sticky flag is set, and it falls one cycle after that condition ends.
- R9: A synchronous active-high `rst` clears the accumulator, all pipeline valid bits, `status`, `irq`, `out_result` and `out_ovf`. Operations in flight are discarded.
- R10: A cycle with `in_valid` low leaves the accumulator unchanged and produces no valid output, whatever the op code and operands are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe |
| in_op | input | 2 | Operation code |
| in_a | input | 64 | First operand, two 32-bit lanes |
| in_b | input | 64 | Second operand, two 32-bit lanes |
| sr_wr | input | 1 | Status register write strobe |
| sr_wdata | input | 3 | Status write value |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Two-lane result |
| out_ovf | output | 2 | Per-lane overflow of this result |
| status | output | 3 | Sticky overflow flags and interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a status write that lands on the same edge at which an in-flight multiply-accumulate latches its overflow. The ports only show that edge two cycles after issue. The bench first loads both lanes with the largest positive value and issues an overflowing accumulate. It then asserts the write exactly two cycles later, with zero data, and expects both flags to survive the write. Dependent accumulate chains are driven back to back from the vector table, so the forwarded accumulator is used at every issue. A reset is also applied with an operation still in the pipeline.

// File: rtl/simd_mac_pkg.sv
package simd_mac_pkg;
  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_MAC  = 2'b01,
    OP_CLR  = 2'b10,
    OP_LOAD = 2'b11
  } op_t;
endpackage

// File: rtl/simd_mac_lane.sv
module simd_mac_lane
  import simd_mac_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_valid,
  input  op_t               s1_op,
  input  logic [LANE_W-1:0] s1_a,
  input  logic [LANE_W-1:0] s1_b,
  input  logic              s2_valid,
  input  op_t               s2_op,
  output logic [LANE_W-1:0] res_q,
  output logic              ovf_q,
  output logic              ovf_evt
);
  localparam int MSB = LANE_W - 1;

  logic signed [HALF_W-1:0] ah, bh;
  logic signed [LANE_W-1:0] ah_x, bh_x, prod;
  logic [LANE_W-1:0] p_q, acc_q, sum;
  logic ovf_now;
  logic unused_b;

  assign ah   = s1_a[HALF_W-1:0];
  assign bh   = s1_b[HALF_W-1:0];
  assign ah_x = {{(LANE_W-HALF_W){ah[HALF_W-1]}}, ah};
  assign bh_x = {{(LANE_W-HALF_W){bh[HALF_W-1]}}, bh};
  assign prod = ah_x * bh_x;
  assign unused_b = ^s1_b[LANE_W-1:HALF_W];

  // stage 2: product, or the load value
  always_ff @(posedge clk) begin
    if (rst)
      p_q <= '0;
    else if (s1_valid)
      p_q <= (s1_op == OP_LOAD) ? s1_a : prod;
  end

  // stage 3: accumulate against the live accumulator register
  assign sum     = acc_q + p_q;
  assign ovf_now = (acc_q[MSB] == p_q[MSB]) && (sum[MSB] != acc_q[MSB]);
  assign ovf_evt = s2_valid && (s2_op == OP_MAC) && ovf_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      res_q <= '0;
      ovf_q <= 1'b0;
    end else if (s2_valid) begin
      ovf_q <= 1'b0;
      case (s2_op)
        OP_MAC: begin
          acc_q <= sum;
          res_q <= sum;
          ovf_q <= ovf_now;
        end
        OP_CLR: begin
          acc_q <= '0;
          res_q <= '0;
        end
        default: begin
          acc_q <= p_q;
          res_q <= p_q;
        end
      endcase
    end
  end

  a_r4_clear: assert property (@(posedge clk) disable iff (rst)
    (s2_valid && s2_op == OP_CLR) |=> (acc_q == '0 && res_q == '0));
  a_r3_mac_result: assert property (@(posedge clk) disable iff (rst)
    (s2_valid && s2_op == OP_MAC) |=> (res_q == acc_q));
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!s2_valid) |=> $stable(acc_q));
endmodule

// File: rtl/simd_mac_status.sv
module simd_mac_status #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] ovf_evt,
  input  logic             sr_wr,
  input  logic [LANES:0]   sr_wdata,
  output logic [LANES:0]   status,
  output logic             irq
);
  logic [LANES-1:0] sticky_q;
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky_q <= '0;
      en_q     <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (sr_wr) begin
        sticky_q <= sr_wdata[LANES-1:0] | ovf_evt;
        en_q     <= sr_wdata[LANES];
      end else begin
        sticky_q <= sticky_q | ovf_evt;
      end
      irq <= en_q && (|sticky_q);
    end
  end

  assign status = {en_q, sticky_q};

  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (!sr_wr) |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));
  a_r8_irq: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(en_q) && $past(|sticky_q)));
endmodule

// File: rtl/simd_mac.sv
module simd_mac
  import simd_mac_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 32,
  parameter int HALF_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [1:0]              in_op,
  input  logic [LANES*LANE_W-1:0] in_a,
  input  logic [LANES*LANE_W-1:0] in_b,
  input  logic                    sr_wr,
  input  logic [LANES:0]          sr_wdata,
  output logic                    out_valid,
  output logic [LANES*LANE_W-1:0] out_result,
  output logic [LANES-1:0]        out_ovf,
  output logic [LANES:0]          status,
  output logic                    irq
);
  localparam int DW = LANES * LANE_W;

  logic          v1_q, v2_q, v3_q;
  op_t           op1_q, op2_q;
  logic [DW-1:0] a1_q, b1_q, res3;
  logic [LANES-1:0] ovf3, evt;
  logic [2:0]    since_rst;

  // stage 1: operand capture
  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q  <= 1'b0;
      v2_q  <= 1'b0;
      v3_q  <= 1'b0;
      op1_q <= OP_MUL;
      op2_q <= OP_MUL;
      a1_q  <= '0;
      b1_q  <= '0;
    end else begin
      v1_q  <= in_valid;
      v2_q  <= v1_q;
      v3_q  <= v2_q;
      op2_q <= op1_q;
      if (in_valid) begin
        op1_q <= op_t'(in_op);
        a1_q  <= in_a;
        b1_q  <= in_b;
      end
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    simd_mac_lane #(.LANE_W(LANE_W), .HALF_W(HALF_W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .s1_valid (v1_q),
      .s1_op    (op1_q),
      .s1_a     (a1_q[i*LANE_W +: LANE_W]),
      .s1_b     (b1_q[i*LANE_W +: LANE_W]),
      .s2_valid (v2_q),
      .s2_op    (op2_q),
      .res_q    (res3[i*LANE_W +: LANE_W]),
      .ovf_q    (ovf3[i]),
      .ovf_evt  (evt[i])
    );
  end

  simd_mac_status #(.LANES(LANES)) u_status (
    .clk      (clk),
    .rst      (rst),
    .ovf_evt  (evt),
    .sr_wr    (sr_wr),
    .sr_wdata (sr_wdata),
    .status   (status),
    .irq      (irq)
  );

  // stage 4: registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_ovf    <= '0;
    end else begin
      out_valid  <= v3_q;
      out_result <= res3;
      out_ovf    <= v3_q ? ovf3 : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      since_rst <= '0;
    else if (since_rst != 3'd4)
      since_rst <= since_rst + 3'd1;
  end

  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));
  a_r6_ovf_valid: assert property (@(posedge clk) disable iff (rst)
    (out_ovf != '0) |-> out_valid);
endmodule

// File: tb/simd_mac_test.sv
`timescale 1ns/1ps
module simd_mac_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] in_op = 2'b00;
  logic [63:0] in_a = '0, in_b = '0;
  logic sr_wr = 1'b0;
  logic [2:0] sr_wdata = '0;
  logic out_valid;
  logic [63:0] out_result;
  logic [1:0] out_ovf;
  logic [2:0] status;
  logic irq;

  always #2.5 clk = ~clk;

  simd_mac uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
    .out_valid(out_valid), .out_result(out_result), .out_ovf(out_ovf),
    .status(status), .irq(irq)
  );

  typedef struct packed {
    logic        v;
    logic [1:0]  op;
    logic [63:0] a;
    logic [63:0] b;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd3, 64'h00000005_FFFFFFF0, 64'h0},
    '{1'b1, 2'd1, 64'h0000_0003_0000_FFFE, 64'h0000_0004_0000_0007},
    '{1'b1, 2'd1, 64'h0000_0003_0000_FFFE, 64'h0000_0004_0000_0007},
    '{1'b1, 2'd0, 64'h1234_8000_0000_7FFF, 64'h0000_8000_ABCD_7FFF},
    '{1'b1, 2'd1, 64'h1234_8000_0000_7FFF, 64'h0000_8000_0000_7FFF},
    '{1'b0, 2'd3, 64'hDEAD_BEEF_DEAD_BEEF, 64'h1111_2222_3333_4444},
    '{1'b1, 2'd1, 64'h0000_8000_0000_7FFF, 64'h0000_8000_0000_7FFF},
    '{1'b1, 2'd2, 64'h5555_5555_5555_5555, 64'h1},
    '{1'b1, 2'd1, 64'h0000_0001_0000_0001, 64'h0000_FFFF_0000_0002},
    '{1'b1, 2'd3, 64'h7FFFFFFF_80000000, 64'h0},
    '{1'b1, 2'd1, 64'h0000_0001_0000_0001, 64'h0000_0001_0000_FFFF},
    '{1'b1, 2'd0, 64'h0000_1234_0000_0000, 64'h0000_0000_0000_7FFF},
    '{1'b0, 2'd2, 64'h0, 64'h0},
    '{1'b1, 2'd1, 64'h0000_0002_0000_FFFD, 64'h0000_0003_0000_0005}
  };

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;
  logic [31:0] m_acc [2];
  logic [1:0]  m_sticky = 2'b00;

  logic        r_used [4];
  logic        r_v    [4];
  logic [63:0] r_res  [4];
  logic [1:0]  r_ovf  [4];
  string       r_tag  [4];
  int slot = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_ring();
    for (int k = 0; k < 4; k++) r_used[k] = 1'b0;
  endtask

  // one cycle: check the op issued four steps ago, then drive a new one
  task automatic step(input logic v, input logic [1:0] op,
                      input logic [63:0] a, input logic [63:0] b, input string tag);
    logic [63:0] er;
    logic [1:0]  eo;
    @(negedge clk);
    if (r_used[slot]) begin
      chk({r_tag[slot], " valid"}, {63'd0, out_valid}, {63'd0, r_v[slot]});
      if (r_v[slot]) begin
        chk({r_tag[slot], " result"}, out_result, r_res[slot]);
        chk("R6 ovf", {62'd0, out_ovf}, {62'd0, r_ovf[slot]});
      end
    end
    er = '0;
    eo = '0;
    if (v) begin
      for (int l = 0; l < 2; l++) begin
        int pa, pb, p, s;
        pa = int'($signed(a[32*l +: 16]));
        pb = int'($signed(b[32*l +: 16]));
        p  = pa * pb;
        case (op)
          2'd0: m_acc[l] = p;
          2'd1: begin
            s = int'(m_acc[l]) + p;
            if ((m_acc[l][31] == p[31]) && (s[31] != m_acc[l][31])) begin
              eo[l] = 1'b1;
              m_sticky[l] = 1'b1;
            end
            m_acc[l] = s;
          end
          2'd2: m_acc[l] = '0;
          default: m_acc[l] = a[32*l +: 32];
        endcase
        er[32*l +: 32] = m_acc[l];
      end
    end
    r_used[slot] = 1'b1;
    r_v[slot]    = v;
    r_res[slot]  = er;
    r_ovf[slot]  = eo;
    r_tag[slot]  = tag;
    slot = (slot + 1) % 4;
    in_valid = v;
    in_op    = op;
    in_a     = a;
    in_b     = b;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 2'd0, 64'h0, 64'h0, "R10");
  endtask

  initial begin
    m_acc[0] = '0;
    m_acc[1] = '0;
    clear_ring();
    repeat (3) @(negedge clk);
    chk("R9 reset valid", {63'd0, out_valid}, 64'd0);
    chk("R9 reset result", out_result, 64'd0);
    chk("R9 reset status", {61'd0, status}, 64'd0);
    chk("R9 reset irq", {63'd0, irq}, 64'd0);
    rst = 1'b0;

    // vector table, issued back to back
    for (int i = 0; i < NV; i++) begin
      string t;
      if (!VEC[i].v) t = "R10";
      else case (VEC[i].op)
        2'd0: t = "R2";
        2'd1: t = "R3";
        2'd2: t = "R4";
        default: t = "R5";
      endcase
      step(VEC[i].v, VEC[i].op, VEC[i].a, VEC[i].b, t);
    end
    idle(4);
    chk("R7 sticky after table", {61'd0, status}, {61'd0, 1'b0, m_sticky});
    chk("R8 irq disabled", {63'd0, irq}, 64'd0);

    // interrupt enable
    sr_wr = 1'b1;
    sr_wdata = {1'b1, m_sticky};
    @(negedge clk);
    sr_wr = 1'b0;
    chk("R7 status write", {61'd0, status}, {61'd0, 1'b1, m_sticky});
    chk("R8 irq not yet", {63'd0, irq}, 64'd0);
    @(negedge clk);
    chk("R8 irq raised", {63'd0, irq}, {63'd0, |m_sticky});

    // reset with an operation in flight
    step(1'b1, 2'd3, 64'h00000100_00000200, 64'h0, "R9");
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    clear_ring();
    m_acc[0] = '0;
    m_acc[1] = '0;
    m_sticky = 2'b00;
    chk("R9 mid reset status", {61'd0, status}, 64'd0);
    chk("R9 mid reset irq", {63'd0, irq}, 64'd0);
    chk("R9 mid reset valid", {63'd0, out_valid}, 64'd0);
    step(1'b1, 2'd1, 64'h0000_0003_0000_0002, 64'h0000_0003_0000_0002, "R9 acc cleared");
    idle(5);
    chk("R9 no stale output", {63'd0, out_valid}, 64'd0);

    // overflow latched on the same edge as a clearing status write
    step(1'b1, 2'd3, 64'h7FFFFFFF_7FFFFFFF, 64'h0, "R5");
    step(1'b1, 2'd1, 64'h0000_0001_0000_0001, 64'h0000_0001_0000_0001, "R6");
    step(1'b0, 2'd0, 64'h0, 64'h0, "R10");
    step(1'b0, 2'd0, 64'h0, 64'h0, "R10");
    sr_wr = 1'b1;
    sr_wdata = 3'b000;
    step(1'b0, 2'd0, 64'h0, 64'h0, "R10");
    sr_wr = 1'b0;
    chk("R7 overflow wins over write", {61'd0, status}, 64'd3);
    idle(4);

    // enable, then disable: irq follows one cycle late
    sr_wr = 1'b1;
    sr_wdata = 3'b111;
    @(negedge clk);
    sr_wdata = 3'b000;
    @(negedge clk);
    sr_wr = 1'b0;
    chk("R8 irq held one cycle", {63'd0, irq}, 64'd1);
    chk("R7 write clears", {61'd0, status}, 64'd0);
    @(negedge clk);
    chk("R8 irq dropped", {63'd0, irq}, 64'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule